// File: doc/BRIEF.md
# Single-wire slave identity command stage

This block is the identity-selection stage of a slave on a single-wire bus. It sits between a bit-level link layer and the memory command stage. The link layer detects bus resets and time slots and exchanges single bits with this block. After every bus reset the block collects an eight-bit command, least significant bit first. It then runs one of four identity operations: sending the identity out, comparing the identity the master sends against its own, skipping identification, or skipping or matching while switching the bus to the fast speed. When an operation succeeds, it gives control to the memory stage with a single-cycle pulse.

The 64-bit identity holds a family byte in bits 7:0 and a 48-bit serial number in bits 55:8. Both come from a parameter. Bits 63:56 are a check byte that the block computes itself, one bit per clock, in the 56 cycles after the chip reset. That byte is a CRC-8 with polynomial x^8+x^5+x^4+1 and a zero start value, taken over bits 0 to 55 in ascending order.

Bits move over a valid/ready pair. A bit transfers on a cycle where `slot_valid` and `slot_ready` are both high. While `slot_ready` is low, the block takes nothing. The link layer does not hold the bus for it: a time slot offered then is simply dropped. In a slot where the slave must drive the bus, `tx_valid` is high and `tx_bit` is the value to drive. The link layer returns the slot through the same valid/ready pair once it has completed.

Top module: `swire_rom_stage`

## Requirements
- R1: Identity bits 63:56 equal the CRC-8 (polynomial x^8+x^5+x^4+1, reflected constant 8Ch, start 00h, shifted right) of identity bits 0..55 taken in ascending order. For the default identity body 000001B81C02h this is A2h.
- R2: Out of chip reset, `slot_ready`, `tx_valid`, `mem_go` and `fast_mode` are 0. For the 56 cycles of check-byte computation, a `bus_reset` has no effect and `slot_ready` stays 0 until a later bus reset.
- R3: Once the check byte is ready, a `bus_reset` raises `slot_ready`. The next eight transferred bits form the command byte, first bit in bit 0.
- R4: Command CCh pulses `mem_go` in the cycle after its eighth bit and leaves `fast_mode` unchanged. `slot_ready` then stays 0 until the next bus reset.
- R5: Command 33h raises `tx_valid`. For transfers 0..63, `tx_bit` presents identity bit k on transfer k. `mem_go` pulses after transfer 63.
- R6: Command 55h compares each received bit with identity bit k. If all 64 bits are equal, `mem_go` pulses after the last one. On the first unequal bit, `slot_ready` drops in the next cycle and no `mem_go` follows until a bus reset.
- R7: Command 3Ch sets `fast_mode` and pulses `mem_go` in the cycle after its eighth bit.
- R8: Command 69h sets `fast_mode` after its eighth bit, then compares 64 bits as in R6. `fast_mode` stays set whether or not the comparison succeeds.
- R9: Any other command code drops `slot_ready`, gives no `mem_go` and leaves `fast_mode` unchanged until the next bus reset.
- R10: A `bus_reset` in any state after R2 aborts the operation and restarts command collection. It overrides a transfer in the same cycle. With `reset_long` = 1 it clears `fast_mode`; with `reset_long` = 0 it keeps `fast_mode`.
- R11: `mem_go` is high for exactly one cycle per successful operation.
- R12: `slot_valid` while `slot_ready` is 0 changes neither state nor outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low chip reset |
| bus_reset | input | 1 | One-cycle strobe: the link layer saw a bus reset |
| reset_long | input | 1 | Qualifies `bus_reset`: reset long enough to leave fast speed |
| slot_valid | input | 1 | A completed time slot is offered |
| slot_bit | input | 1 | Bit the master wrote in that slot |
| slot_ready | output | 1 | The block consumes the offered slot |
| tx_valid | output | 1 | Slots are read slots; the slave drives `tx_bit` |
| tx_bit | output | 1 | Bit to drive in the current read slot |
| mem_go | output | 1 | One-cycle hand-off to the memory command stage |
| fast_mode | output | 1 | Fast bus speed selected |

## Verification
The case that needs care is a bus reset that arrives in the same cycle as the eighth bit of a command that would set fast speed or hand off. The bench provokes it by raising `bus_reset` with `reset_long` together with that final `slot_valid`. It then requires no `mem_go`, a cleared `fast_mode` and a fresh command collection, and confirms the last point by running a complete skip command next. A short reset that lands in the middle of an identity send is also checked: it must abort the send and keep the fast speed.

// File: rtl/swire_rom_pkg.sv
package swire_rom_pkg;

  localparam int CMD_BITS = 8;

  typedef enum logic [2:0] {
    ST_CRC,      // check byte being built after chip reset
    ST_WAIT,     // waiting for a bus reset
    ST_CMD,      // collecting the command byte
    ST_SEND,     // shifting the identity out
    ST_CMP,      // comparing received identity bits
    ST_HANDOFF   // memory stage owns the bus
  } rom_state_t;

  localparam logic [CMD_BITS-1:0] OP_READ   = 8'h33;
  localparam logic [CMD_BITS-1:0] OP_MATCH  = 8'h55;
  localparam logic [CMD_BITS-1:0] OP_SKIP   = 8'hCC;
  localparam logic [CMD_BITS-1:0] OP_FSKIP  = 8'h3C;
  localparam logic [CMD_BITS-1:0] OP_FMATCH = 8'h69;

  // one step of the reflected CRC-8 (x^8+x^5+x^4+1)
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? 8'h8C : 8'h00);
  endfunction

endpackage

// File: rtl/swire_rom_crc.sv
module swire_rom_crc
  import swire_rom_pkg::*;
#(
  parameter int              BODY_BITS = 56,
  parameter logic [BODY_BITS-1:0] ID_BODY = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       done,
  output logic [7:0] crc
);
  localparam int CW = $clog2(BODY_BITS + 1);

  logic [CW-1:0] pos;

  assign done = (pos == CW'(BODY_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      crc <= 8'h00;
    end else if (!done) begin
      crc <= crc8_step(crc, ID_BODY[pos]);
      pos <= pos + 1'b1;
    end
  end

  AST_CRC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && $stable(crc)); // R1
  AST_CRC_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> pos == $past(pos) + 1'b1); // R2

endmodule

// File: rtl/swire_rom_cursor.sv
module swire_rom_cursor
  import swire_rom_pkg::*;
#(
  parameter int ID_BITS = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       step,
  output logic [$clog2(ID_BITS)-1:0] idx,
  output logic                       cmd_last,
  output logic                       id_last
);
  localparam int IW = $clog2(ID_BITS);

  assign cmd_last = (idx == IW'(CMD_BITS - 1));
  assign id_last  = (idx == IW'(ID_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= '0;
    else if (clear) idx <= '0;
    else if (step)  idx <= idx + 1'b1;
  end

  AST_CURSOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step && !clear && !id_last |=> idx == $past(idx) + 1'b1); // R3
  AST_CURSOR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> idx == '0); // R10

endmodule

// File: rtl/swire_rom_stage.sv
module swire_rom_stage
  import swire_rom_pkg::*;
#(
  parameter int                   BODY_BITS = 56,
  parameter int                   CRC_BITS  = 8,
  parameter logic [BODY_BITS-1:0] ID_BODY   = 56'h0000_01B8_1C02
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic reset_long,
  input  logic slot_valid,
  input  logic slot_bit,
  output logic slot_ready,
  output logic tx_valid,
  output logic tx_bit,
  output logic mem_go,
  output logic fast_mode
);
  localparam int ID_BITS = BODY_BITS + CRC_BITS;
  localparam int IW      = $clog2(ID_BITS);

  rom_state_t          state;
  logic [CMD_BITS-1:0] cmd_sh, cmd_next;
  logic [7:0]          crc;
  logic                crc_done;
  logic [ID_BITS-1:0]  id_word;
  logic [IW-1:0]       idx;
  logic                cmd_last, id_last;
  logic                take, reset_hit, cur_clear;

  swire_rom_crc #(.BODY_BITS(BODY_BITS), .ID_BODY(ID_BODY)) u_crc (
    .clk(clk), .rst_n(rst_n), .done(crc_done), .crc(crc)
  );

  swire_rom_cursor #(.ID_BITS(ID_BITS)) u_cursor (
    .clk(clk), .rst_n(rst_n), .clear(cur_clear), .step(take),
    .idx(idx), .cmd_last(cmd_last), .id_last(id_last)
  );

  assign id_word    = {crc, ID_BODY};
  assign slot_ready = (state == ST_CMD) || (state == ST_SEND) || (state == ST_CMP);
  assign tx_valid   = (state == ST_SEND);
  assign tx_bit     = id_word[idx];
  assign take       = slot_valid && slot_ready;
  assign reset_hit  = bus_reset && (state != ST_CRC);
  assign cmd_next   = {slot_bit, cmd_sh[CMD_BITS-1:1]};
  assign cur_clear  = reset_hit || (take && (state == ST_CMD) && cmd_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_CRC;
      cmd_sh    <= '0;
      mem_go    <= 1'b0;
      fast_mode <= 1'b0;
    end else begin
      mem_go <= 1'b0;
      if (reset_hit) begin
        state  <= ST_CMD;
        cmd_sh <= '0;
        if (reset_long) fast_mode <= 1'b0;
      end else begin
        unique case (state)
          ST_CRC: if (crc_done) state <= ST_WAIT;
          ST_CMD: if (take) begin
            cmd_sh <= cmd_next;
            if (cmd_last) begin
              case (cmd_next)
                OP_READ:   state <= ST_SEND;
                OP_MATCH:  state <= ST_CMP;
                OP_FMATCH: begin state <= ST_CMP; fast_mode <= 1'b1; end
                OP_SKIP:   begin state <= ST_HANDOFF; mem_go <= 1'b1; end
                OP_FSKIP:  begin state <= ST_HANDOFF; mem_go <= 1'b1; fast_mode <= 1'b1; end
                default:   state <= ST_WAIT;
              endcase
            end
          end
          ST_SEND: if (take && id_last) begin
            state  <= ST_HANDOFF;
            mem_go <= 1'b1;
          end
          ST_CMP: if (take) begin
            if (slot_bit != id_word[idx]) state <= ST_WAIT;
            else if (id_last) begin
              state  <= ST_HANDOFF;
              mem_go <= 1'b1;
            end
          end
          default: state <= state;
        endcase
      end
    end
  end

  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_go |=> !mem_go); // R11
  AST_GO_FROM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_go |-> $past(take)); // R12
  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    reset_hit |=> slot_ready && !tx_valid && !mem_go); // R10
  AST_FAST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    reset_hit && reset_long |=> !fast_mode); // R10
  AST_FAST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    fast_mode && !(bus_reset && reset_long) |=> fast_mode); // R8
  AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> slot_ready); // R5
  AST_QUIET_UNTIL_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_done |-> !slot_ready && !fast_mode && !mem_go); // R2

endmodule

// File: tb/test_swire_rom_stage.sv
`timescale 1ns/1ps
module test_swire_rom_stage;
  localparam logic [55:0] BODY = 56'h0000_01B8_1C02;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_reset = 1'b0, reset_long = 1'b0, slot_valid = 1'b0, slot_bit = 1'b0;
  logic slot_ready, tx_valid, tx_bit, mem_go, fast_mode;
  int   n_chk = 0, n_fail = 0;
  logic [63:0] exp_id, got_id;

  always #2.5 clk = ~clk;

  swire_rom_stage #(.ID_BODY(BODY)) i_swire_rom_stage (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .reset_long(reset_long),
    .slot_valid(slot_valid), .slot_bit(slot_bit), .slot_ready(slot_ready),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .mem_go(mem_go), .fast_mode(fast_mode)
  );

  function automatic logic [7:0] ref_crc(input logic [55:0] b);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ 8'h8C;
      else             c = c >> 1;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic brst(input logic lng);
    bus_reset = 1'b1; reset_long = lng;
    @(negedge clk);
    bus_reset = 1'b0; reset_long = 1'b0;
  endtask

  task automatic slot(input logic b);
    slot_valid = 1'b1; slot_bit = b;
    @(negedge clk);
    slot_valid = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    for (int i = 0; i < 8; i++) slot(c[i]);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    exp_id = {ref_crc(BODY), BODY};
    chk("R1 reference check byte", 64'(exp_id[63:56]), 64'hA2);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R2 reset slot_ready", slot_ready, 0);
    chk("R2 reset tx_valid", tx_valid, 0);
    chk("R2 reset mem_go", mem_go, 0);
    chk("R2 reset fast_mode", fast_mode, 0);
    repeat (10) @(negedge clk);
    brst(1'b1);
    repeat (3) slot(1'b1);
    repeat (60) @(negedge clk);
    chk("R2 early bus reset ignored", slot_ready, 0);
    chk("R12 early slots ignored", mem_go, 0);
    brst(1'b0);
    chk("R3 ready after bus reset", slot_ready, 1);
    chk("R3 no tx in command phase", tx_valid, 0);

    // sweep every command code
    for (int c = 0; c < 256; c++) begin
      logic go_e, fast_e, rdy_e, tx_e;
      brst(1'b1);
      chk("R10 long reset clears fast", fast_mode, 0);
      send_cmd(8'(c));
      go_e   = (c == 8'hCC) || (c == 8'h3C);
      fast_e = (c == 8'h3C) || (c == 8'h69);
      rdy_e  = (c == 8'h33) || (c == 8'h55) || (c == 8'h69);
      tx_e   = (c == 8'h33);
      chk(go_e ? "R4 R7 go after command" : "R9 no go", mem_go, go_e);
      chk(fast_e ? "R7 R8 fast set" : "R4 R9 fast unchanged", fast_mode, fast_e);
      chk(rdy_e ? "R5 R6 R8 ready kept" : "R9 R4 ready dropped", slot_ready, rdy_e);
      chk("R5 tx_valid per command", tx_valid, tx_e);
      if (!rdy_e) begin
        @(negedge clk);
        chk("R11 go is one cycle", mem_go, 0);
        repeat (2) slot(1'b0);
        chk("R12 dropped slots no go", mem_go, 0);
        chk("R12 dropped slots no ready", slot_ready, 0);
      end else if (tx_e) begin
        got_id = '0;
        for (int k = 0; k < 64; k++) begin
          got_id[k] = tx_bit;
          if (k < 63) chk("R5 no early go", mem_go, 0);
          slot(1'b1);
        end
        chk("R5 identity sent", got_id, exp_id);
        chk("R1 check byte in identity", 64'(got_id[63:56]), 64'(ref_crc(BODY)));
        chk("R5 go after send", mem_go, 1);
      end else begin
        for (int k = 0; k < 64; k++) slot(exp_id[k]);
        chk(c == 8'h55 ? "R6 match go" : "R8 fast match go", mem_go, 1);
        chk("R8 fast after match", fast_mode, fast_e);
      end
    end

    // mismatch at every position, both compare commands
    for (int p = 0; p < 64; p++) begin
      for (int m = 0; m < 2; m++) begin
        brst(1'b1);
        send_cmd(m == 0 ? 8'h55 : 8'h69);
        for (int k = 0; k < p; k++) slot(exp_id[k]);
        slot(~exp_id[p]);
        chk(m == 0 ? "R6 mismatch drops ready" : "R8 mismatch drops ready", slot_ready, 0);
        for (int k = p + 1; k < 64; k++) slot(exp_id[k]);
        chk(m == 0 ? "R6 mismatch no go" : "R8 mismatch no go", mem_go, 0);
        chk("R8 fast held after mismatch", fast_mode, m);
      end
    end

    // bus reset coinciding with the final bit of a fast skip
    brst(1'b1);
    for (int i = 0; i < 7; i++) slot(1'(8'h3C >> i));
    slot_valid = 1'b1; slot_bit = 1'b0; bus_reset = 1'b1; reset_long = 1'b1;
    @(negedge clk);
    slot_valid = 1'b0; bus_reset = 1'b0; reset_long = 1'b0;
    chk("R10 reset wins over last bit: go", mem_go, 0);
    chk("R10 reset wins over last bit: fast", fast_mode, 0);
    chk("R10 reset restarts command", slot_ready, 1);
    send_cmd(8'hCC);
    chk("R10 fresh command after collision", mem_go, 1);
    chk("R4 skip keeps fast clear", fast_mode, 0);

    // short reset inside a send keeps fast speed
    brst(1'b1);
    send_cmd(8'h3C);
    chk("R7 fast skip sets fast", fast_mode, 1);
    brst(1'b0);
    send_cmd(8'hCC);
    chk("R4 skip keeps fast set", fast_mode, 1);
    brst(1'b0);
    send_cmd(8'h33);
    repeat (5) slot(1'b1);
    brst(1'b0);
    chk("R10 short reset keeps fast", fast_mode, 1);
    chk("R10 short reset aborts send", tx_valid, 0);
    chk("R10 short reset ready", slot_ready, 1);
    brst(1'b1);
    chk("R10 long reset clears fast", fast_mode, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule